// File: doc/BRIEF.md
# Interleaved Two-Colour Pixel Fetcher

This block turns a raster position into a palette-mapped pixel for a 640 by 200 graphics mode with two colours per pixel. The frame buffer lives in an external 16 KB video RAM. It is split into two 8 KB halves by scanline parity: even lines sit in the lower half and odd lines in the upper half. The block is enabled when the memory-mapping select equals a fixed code. In that mode the active area is always 640 by 200.

For each active raster position the block forms a byte address and issues a read. The RAM returns the byte one cycle later. The block then selects the pixel bit from that byte and forms a 3-bit index. The index addresses a 16-entry palette register file, and the palette entry leaves the block unchanged as an 8-bit DAC register number, together with a valid strobe and the pixel's coordinates. A simple write port loads the palette.

Top module: `cga_mono_fetch`

## Requirements
- R1: A read is issued (`vram_rd` high) and a pixel later becomes valid only when `raster_en` is high, `map_sel` equals 3, `raster_x` is below 640 and `raster_y` is below 200. In every other case `vram_rd` stays low and no valid pixel results.
- R2: Bit 13 of `vram_addr` equals bit 0 of `raster_y`, so odd lines are read from offset 0x2000 upward.
- R3: The address bits below bit 13 contain 80 times (`raster_y` >> 1), plus the column byte.
- R4: The column byte added to the address is `raster_x` >> 3. The address is combinational from the raster inputs, in the same cycle as `vram_rd`.
- R5: The returned byte is shifted right by 7 − (`raster_x` mod 8), which puts the most significant bit leftmost. The low two bits of the shifted byte form bits 1:0 of the palette index.
- R6: Bit 2 of the palette index is `line_gfx` as sampled with the raster position. Bit 3 is 0.
- R7: `pix_code` equals the palette entry at that index, with no further change.
- R8: `pix_valid`, `pix_x` and `pix_y` appear exactly 2 clock cycles after the raster inputs are presented, in order and without gaps for back-to-back pixels.
- R9: A palette write with `pal_we` is visible to pixels whose output is registered after the write edge. A pixel registered on the same edge as the write gets the old entry.
- R10: While reset is active and just after it, `pix_valid` and `vram_rd` are low, `pix_code` is 0, and every palette entry reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| map_sel | input | 2 | Memory-mapping select; code 3 enables this mode |
| raster_en | input | 1 | Raster position is a pixel request |
| raster_x | input | 10 | Horizontal position |
| raster_y | input | 9 | Vertical position |
| line_gfx | input | 1 | Line-graphics enable, placed at palette index bit 2 |
| pal_we | input | 1 | Palette write strobe |
| pal_waddr | input | 4 | Palette entry to write |
| pal_wdata | input | 8 | Palette write data |
| vram_addr | output | 14 | Video RAM byte address |
| vram_rd | output | 1 | Video RAM read request |
| vram_rdata | input | 8 | Video RAM data, one cycle after the request |
| pix_valid | output | 1 | Output pixel valid |
| pix_code | output | 8 | DAC register number |
| pix_x | output | 10 | Horizontal position of the output pixel |
| pix_y | output | 9 | Vertical position of the output pixel |

## Verification
The bench drives lines at both parities, including lines 0, 1, 198 and 199 and the last column byte. A design that swaps the parity halves or uses y instead of y >> 1 would put the wrong address on the port in the same cycle. Every pixel position within a byte is covered. Position 0 is included on purpose, because there the second index bit must be 0: a design that wraps or reverses the bit order returns a different palette entry. `line_gfx` is toggled between pixels, so a pipeline that samples it late would pick the wrong bank. The bench also rewrites a palette entry on the very edge that outputs a pixel using that entry. A design that bypasses the write data to the output, or that delays the write, would fail that check. Positions outside the active area and other mapping codes must cause neither a read nor an output.

// File: rtl/cgafetch_pkg.sv
package cgafetch_pkg;
    localparam int X_W    = 10;
    localparam int Y_W    = 9;
    localparam int CODE_W = 8;

    // request stage: one raster position in flight to the RAM
    typedef struct packed {
        logic           vld;
        logic [X_W-1:0] x;
        logic [Y_W-1:0] y;
        logic           lg;
        logic [2:0]     bsel;
    } req_stage_t;

    // output stage: one finished pixel
    typedef struct packed {
        logic              vld;
        logic [CODE_W-1:0] code;
        logic [X_W-1:0]    x;
        logic [Y_W-1:0]    y;
    } pix_stage_t;
endpackage

// File: rtl/cgafetch_addr.sv
module cgafetch_addr
    import cgafetch_pkg::*;
#(
    parameter int H_ACTIVE   = 640,
    parameter int V_ACTIVE   = 200,
    parameter int MAP_SEL    = 3,
    parameter int ADDR_W     = 14,
    parameter int BANK_SHIFT = 13
) (
    input  logic [1:0]        map_sel,
    input  logic              en,
    input  logic [X_W-1:0]    x,
    input  logic [Y_W-1:0]    y,
    output logic              active,
    output logic [ADDR_W-1:0] addr
);
    localparam int LINE_BYTES = H_ACTIVE / 8;

    logic        in_area;
    logic [31:0] full_addr;

    always_comb begin
        in_area   = (32'(x) < 32'(H_ACTIVE)) && (32'(y) < 32'(V_ACTIVE));
        active    = en && (32'(map_sel) == 32'(MAP_SEL)) && in_area;
        full_addr = (32'(y[0]) << BANK_SHIFT)
                  + 32'(LINE_BYTES) * 32'(y >> 1)
                  + 32'(x >> 3);
        addr      = active ? full_addr[ADDR_W-1:0] : '0;
    end
endmodule

// File: rtl/cgafetch_palette.sv
module cgafetch_palette
    import cgafetch_pkg::*;
#(
    parameter int PAL_N = 16,
    localparam int IDX_W = $clog2(PAL_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [CODE_W-1:0] wdata,
    input  logic [IDX_W-1:0]  ridx,
    output logic [CODE_W-1:0] rdata
);
    logic [CODE_W-1:0] pal_d [PAL_N];
    logic [CODE_W-1:0] pal_q [PAL_N];

    for (genvar g = 0; g < PAL_N; g++) begin : g_entry
        always_comb begin
            pal_d[g] = pal_q[g];
            if (we && (32'(waddr) == g))
                pal_d[g] = wdata;
        end

        always_ff @(posedge clk) begin
            if (!rst_n)
                pal_q[g] <= '0;
            else
                pal_q[g] <= pal_d[g];
        end
    end

    // read sees registered contents only: same-edge write gives old value
    assign rdata = pal_q[ridx];

    AST_PAL_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> pal_q[$past(waddr)] == $past(wdata)); // R9
endmodule

// File: rtl/cga_mono_fetch.sv
module cga_mono_fetch
    import cgafetch_pkg::*;
#(
    parameter int H_ACTIVE   = 640,
    parameter int V_ACTIVE   = 200,
    parameter int MAP_SEL    = 3,
    parameter int ADDR_W     = 14,
    parameter int BANK_SHIFT = 13,
    parameter int PAL_N      = 16,
    localparam int IDX_W     = $clog2(PAL_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        map_sel,
    input  logic              raster_en,
    input  logic [X_W-1:0]    raster_x,
    input  logic [Y_W-1:0]    raster_y,
    input  logic              line_gfx,
    input  logic              pal_we,
    input  logic [IDX_W-1:0]  pal_waddr,
    input  logic [CODE_W-1:0] pal_wdata,
    output logic [ADDR_W-1:0] vram_addr,
    output logic              vram_rd,
    input  logic [7:0]        vram_rdata,
    output logic              pix_valid,
    output logic [CODE_W-1:0] pix_code,
    output logic [X_W-1:0]    pix_x,
    output logic [Y_W-1:0]    pix_y
);
    localparam int LINE_BYTES = H_ACTIVE / 8;
    localparam int BANK_BYTES = LINE_BYTES * ((V_ACTIVE + 1) / 2);

    logic              act;
    logic [7:0]        shifted;
    logic [IDX_W-1:0]  pal_idx;
    logic [CODE_W-1:0] pal_out;

    req_stage_t req_d, req_q;
    pix_stage_t pix_d, pix_q;

    cgafetch_addr #(
        .H_ACTIVE  (H_ACTIVE),
        .V_ACTIVE  (V_ACTIVE),
        .MAP_SEL   (MAP_SEL),
        .ADDR_W    (ADDR_W),
        .BANK_SHIFT(BANK_SHIFT)
    ) u_addr (
        .map_sel(map_sel),
        .en     (raster_en),
        .x      (raster_x),
        .y      (raster_y),
        .active (act),
        .addr   (vram_addr)
    );

    cgafetch_palette #(.PAL_N(PAL_N)) u_pal (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (pal_we),
        .waddr(pal_waddr),
        .wdata(pal_wdata),
        .ridx (pal_idx),
        .rdata(pal_out)
    );

    assign vram_rd = act;

    always_comb begin
        // request stage tracks the RAM's one-cycle read
        req_d      = '0;
        req_d.vld  = act;
        if (act) begin
            req_d.x    = raster_x;
            req_d.y    = raster_y;
            req_d.lg   = line_gfx;
            req_d.bsel = raster_x[2:0];
        end

        // pixel stage: bit select, index build, palette lookup
        shifted = vram_rdata >> (3'd7 - req_q.bsel);
        pal_idx = IDX_W'({req_q.lg, shifted[1:0]});

        pix_d = '0;
        if (req_q.vld) begin
            pix_d.vld  = 1'b1;
            pix_d.code = pal_out;
            pix_d.x    = req_q.x;
            pix_d.y    = req_q.y;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= '0;
            pix_q <= '0;
        end else begin
            req_q <= req_d;
            pix_q <= pix_d;
        end
    end

    assign pix_valid = pix_q.vld;
    assign pix_code  = pix_q.code;
    assign pix_x     = pix_q.x;
    assign pix_y     = pix_q.y;

    AST_VALID_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> $past(map_sel, 2) == 2'(MAP_SEL)); // R1
    AST_BANK_MATCHES_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> $past(vram_addr[BANK_SHIFT], 2) == pix_y[0]); // R2
    AST_ADDR_IN_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        vram_rd |-> 32'(vram_addr[BANK_SHIFT-1:0]) < BANK_BYTES); // R3
    AST_VALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> $past(vram_rd, 2)); // R8
    AST_IDLE_AFTER_RESET: assert property (@(posedge clk)
        !rst_n |=> !pix_valid); // R10
endmodule

// File: tb/sim_cga_mono_fetch.sv
module sim_cga_mono_fetch;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] map_sel = 2'd0;
    logic       raster_en = 1'b0;
    logic [9:0] raster_x = '0;
    logic [8:0] raster_y = '0;
    logic       line_gfx = 1'b0;
    logic       pal_we = 1'b0;
    logic [3:0] pal_waddr = '0;
    logic [7:0] pal_wdata = '0;
    logic [13:0] vram_addr;
    logic       vram_rd;
    logic [7:0] vram_rdata = '0;
    logic       pix_valid;
    logic [7:0] pix_code;
    logic [9:0] pix_x;
    logic [8:0] pix_y;

    typedef struct {
        logic [7:0] code;
        int         x;
        int         y;
        int         due;
    } item_t;

    item_t      sb[$];
    logic [7:0] mem [16384];
    logic [7:0] pal_model [16];
    int cyc = 0, total = 0, bad = 0;
    bit done = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always @(posedge clk) if (vram_rd) vram_rdata <= mem[vram_addr];

    cga_mono_fetch u0 (
        .clk(clk), .rst_n(rst_n), .map_sel(map_sel), .raster_en(raster_en),
        .raster_x(raster_x), .raster_y(raster_y), .line_gfx(line_gfx),
        .pal_we(pal_we), .pal_waddr(pal_waddr), .pal_wdata(pal_wdata),
        .vram_addr(vram_addr), .vram_rd(vram_rd), .vram_rdata(vram_rdata),
        .pix_valid(pix_valid), .pix_code(pix_code), .pix_x(pix_x), .pix_y(pix_y)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // driver: present one raster position, check the address port, queue the result
    task automatic px(input int x, input int y, input bit lg, input bit en = 1,
                      input int mode = 3, input bit do_wr = 0,
                      input int wa = 0, input int wv = 0);
        bit act;
        int ea;
        logic [7:0] sh;
        item_t it;
        @(negedge clk);
        raster_x = 10'(x); raster_y = 9'(y); line_gfx = lg;
        raster_en = en; map_sel = 2'(mode);
        pal_we = do_wr; pal_waddr = 4'(wa); pal_wdata = 8'(wv);
        if (do_wr) pal_model[wa] = 8'(wv);
        #1;
        act = en && mode == 3 && x < 640 && y < 200;
        check(vram_rd == act, "R1 read request", int'(vram_rd), int'(act));
        if (act) begin
            ea = ((y % 2) * 8192) + 80 * (y / 2) + x / 8;
            check(int'(vram_addr) == ea, "R2 R3 R4 address", int'(vram_addr), ea);
            sh = mem[ea] >> (7 - (x % 8));           // R5 MSB leftmost
            it.code = pal_model[{lg, sh[1:0]}];      // R6 bit 2 from line_gfx
            it.x = x; it.y = y; it.due = cyc + 2;    // R8 two-cycle lag
            sb.push_back(it);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            raster_en = 1'b0; pal_we = 1'b0;
        end
    endtask

    // monitor: pop and compare as pixels emerge
    always @(negedge clk) begin
        #2;
        if (rst_n && pix_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R1 unexpected pixel", 1, 0);
            end else begin
                item_t e;
                e = sb.pop_front();
                check(pix_code == e.code, "R7 R5 R6 code", int'(pix_code), int'(e.code));
                check(int'(pix_x) == e.x && int'(pix_y) == e.y, "R8 coords",
                      {int'(pix_y), 16'(pix_x)}, {e.y, 16'(e.x)});
                check(cyc == e.due, "R8 latency", cyc, e.due);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog", cyc, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16384; i++) mem[i] = 8'((i * 37) ^ (i >> 4) ^ 8'h5A);
        for (int i = 0; i < 16; i++) pal_model[i] = 8'h00;
        repeat (3) @(negedge clk);
        #1;
        // R10 reset state
        check(!pix_valid && pix_code == 8'h00 && !vram_rd, "R10 reset outputs",
              {pix_valid, pix_code}, 0);
        @(negedge clk); rst_n = 1'b1;
        // R10 palette cleared: read entry via a pixel before programming
        px(0, 0, 0); px(13, 5, 1); idle(4);

        // program the palette (R7: distinct codes per entry)
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            pal_we = 1'b1; pal_waddr = 4'(i); pal_wdata = 8'(8'h11 * i + 8'h07);
            pal_model[i] = 8'(8'h11 * i + 8'h07);
        end
        idle(2);

        // R5: every bit position of several bytes, even line
        for (int x = 0; x < 24; x++) px(x, 0, x[1]);
        // R2: odd lines, end of line
        for (int x = 624; x < 640; x++) px(x, 1, x[0]);
        // R3: last lines of both banks
        for (int x = 0; x < 16; x++) px(x, 199, 1);
        for (int x = 300; x < 316; x++) px(x, 198, 0);
        idle(4);

        // R1: inactive requests produce nothing
        px(10, 10, 0, 1, 2);
        px(640, 10, 0);
        px(5, 200, 0);
        px(5, 10, 0, 0, 3);
        px(1023, 511, 1, 1, 1);
        idle(4);

        // R9: write on the edge that registers a pixel using that entry
        px(16, 2, 1);                              // old entry
        px(16, 2, 1, 1, 3, 1, 0, 0);               // placeholder refresh: index may differ
        idle(4);
        begin
            logic [7:0] sh;
            int ea;
            ea = 80 + 2;  // y=2 -> line 1 of even bank, x=16 -> byte 2
            sh = mem[ea] >> 7;
            px(16, 2, 1);                                          // gets old value
            px(16, 2, 1, 1, 3, 1, int'({1'b1, sh[1:0]}), 8'hC3);   // gets new value
        end
        idle(4);

        // R8: long random back-to-back stream
        for (int i = 0; i < 400; i++)
            px($urandom_range(0, 639), $urandom_range(0, 199), 1'($urandom_range(0, 1)));
        idle(5);

        check(sb.size() == 0, "R8 all pixels delivered", sb.size(), 0);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule